// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This block frees an I2C bus when a target device holds SDA low partway through a byte. A single trigger makes it take control of SCL through an open-drain pull-down. It then clocks out a fixed number of pulses, which lets the stuck target shift out the rest of its byte and see a not-acknowledge, because SDA stays released during the pulses. After the pulses it closes the bus with a STOP condition and reports that it has finished. Both bus outputs are pull enables: 1 pulls the wire low and 0 lets the external pull-up raise it. Every bus phase lasts `HALF_CYCLES` system clocks, which is the half period of the recovery clock. A 20 µs half period corresponds to a fixed count of system clocks.

The sequence is run by a state machine with these states:
- `ST_IDLE`: waits for the trigger and drives nothing.
- `ST_PULSE_LO`: pulls SCL low.
- `ST_PULSE_HI`: releases SCL.
- `ST_STOP_LO`: pulls SCL and SDA low.
- `ST_STOP_SU`: releases SCL and keeps SDA low.
- `ST_STOP_REL`: releases both lines, which forms the STOP edge, and then holds bus-free time.
- `ST_FINISH`: raises done for one clock.

The transitions are:
- idle→pulse-low when the trigger is seen.
- pulse-low→pulse-high when a half period expires.
- pulse-high→pulse-low when a half period expires and pulses remain.
- pulse-high→stop-low when a half period expires after the last pulse.
- stop-low→stop-setup when a half period expires.
- stop-setup→stop-release when a half period expires.
- stop-release→finish when a half period expires.
- finish→idle unconditionally.

A half-period timer and a pulse counter sit beside the state machine.

Top module: `bus_clear_seq`

## Requirements
- R1: While reset is active and right after reset, `scl_pull_o`, `sda_pull_o`, `busy_o` and `done_o` are all 0.
- R2: A run produces exactly `NUM_PULSES` SCL pull-down pulses with SDA released, followed by one more SCL low phase that belongs to the STOP. That makes NUM_PULSES+1 rising edges of `scl_pull_o` per run.
- R3: Every SCL low phase and every SCL high phase inside a run lasts exactly `HALF_CYCLES` clocks.
- R4: `sda_pull_o` stays 0 from the trigger until the last pulse has released SCL.
- R5: The STOP has three steps, each lasting `HALF_CYCLES` clocks. First SDA is pulled in the same cycle that SCL is pulled. Then SCL is released while SDA stays pulled. Then SDA is released while SCL is released. SDA never changes while SCL is released, except at that final STOP release.
- R6: `busy_o` rises the clock after a trigger is accepted. It stays 1 for exactly (2·NUM_PULSES+3)·HALF_CYCLES clocks and stays high for `HALF_CYCLES` clocks after SDA is released.
- R7: `done_o` is a one-clock pulse in the cycle right after `busy_o` falls, and `busy_o` is 0 in that cycle.
- R8: `start_i` is ignored while a run is busy and in the done cycle. A run with extra triggers has the same length and pulse count as a clean run, and a trigger in the done cycle starts no new run.
- R9: With `start_i` held at 1, a new run starts with only one idle cycle after the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Trigger. Sampled when the block is idle. |
| scl_pull_o | output | 1 | SCL open-drain enable (1 pulls low) |
| sda_pull_o | output | 1 | SDA open-drain enable (1 pulls low) |
| busy_o | output | 1 | High from the trigger until the STOP completes |
| done_o | output | 1 | One-clock completion pulse |

## Verification
A clean single trigger sets the baseline for the whole run:
- the pulse count
- the length of each phase
- the STOP ordering
- the busy length
- the position of done

A run that gets a second trigger halfway through the pulse train shows whether the trigger is guarded while busy. A trigger in the done cycle shows whether the trigger is guarded in the finish state, because a leak would restart the sequence. A trigger held high continuously measures the gap between runs. A reset applied partway through a run, followed by a fresh run, shows that the pulse counter is cleared rather than carried over.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE_LO,
        ST_PULSE_HI,
        ST_STOP_LO,
        ST_STOP_SU,
        ST_STOP_REL,
        ST_FINISH
    } busclr_state_e;

endpackage

// File: rtl/busclr_half_timer.sv
module busclr_half_timer #(
    parameter int HALF_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    // Restart the count when cleared or when a half period ends
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/busclr_pulse_ctr.sv
module busclr_pulse_ctr #(
    parameter int NUM_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(NUM_PULSES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_PULSES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cnt_q < CNT_W'(NUM_PULSES)));

endmodule

// File: rtl/busclr_fsm.sv
module busclr_fsm
    import busclr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    input  logic last_pulse_i,
    output logic timer_clear_o,
    output logic pulse_clear_o,
    output logic pulse_step_o,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic done_o
);
    busclr_state_e state_q, state_d;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_PULSE_LO;
            ST_PULSE_LO: if (tick_i)  state_d = ST_PULSE_HI;
            ST_PULSE_HI: if (tick_i)  state_d = last_pulse_i ? ST_STOP_LO : ST_PULSE_LO;
            ST_STOP_LO:  if (tick_i)  state_d = ST_STOP_SU;
            ST_STOP_SU:  if (tick_i)  state_d = ST_STOP_REL;
            ST_STOP_REL: if (tick_i)  state_d = ST_FINISH;
            ST_FINISH:                state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs taken from the next state, so pins change with the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pull_o <= 1'b0;
            sda_pull_o <= 1'b0;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            scl_pull_o <= (state_d == ST_PULSE_LO) || (state_d == ST_STOP_LO);
            sda_pull_o <= (state_d == ST_STOP_LO)  || (state_d == ST_STOP_SU);
            busy_o     <= (state_d != ST_IDLE)     && (state_d != ST_FINISH);
            done_o     <= (state_d == ST_FINISH);
        end
    end

    assign timer_clear_o = (state_q == ST_IDLE) || (state_q == ST_FINISH);
    assign pulse_clear_o = (state_q == ST_IDLE);
    assign pulse_step_o  = (state_q == ST_PULSE_HI) && tick_i;

    // R3
    timed_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != $past(state_q)) && ($past(state_q) != ST_IDLE)
         && ($past(state_q) != ST_FINISH)) |-> $past(tick_i));

    // R6
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: rtl/bus_clear_seq.sv
module bus_clear_seq #(
    parameter int HALF_CYCLES = 2000,
    parameter int NUM_PULSES  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic done_o
);
    logic tick;
    logic last_pulse;
    logic timer_clear;
    logic pulse_clear;
    logic pulse_step;

    busclr_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (timer_clear),
        .tick_o  (tick)
    );

    busclr_pulse_ctr #(.NUM_PULSES(NUM_PULSES)) u_pulses (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pulse_clear),
        .step_i  (pulse_step),
        .last_o  (last_pulse)
    );

    busclr_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .tick_i        (tick),
        .last_pulse_i  (last_pulse),
        .timer_clear_o (timer_clear),
        .pulse_clear_o (pulse_clear),
        .pulse_step_o  (pulse_step),
        .scl_pull_o    (scl_pull_o),
        .sda_pull_o    (sda_pull_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    // R5
    sda_pull_under_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> scl_pull_o);

    // R5
    stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> (!scl_pull_o && $past(!scl_pull_o)));

    // R4
    sda_idle_in_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$past(busy_o)) |-> !sda_pull_o);

endmodule

// File: tb/bus_clear_seq_test.sv
module bus_clear_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int H = 5;
    localparam int N = 9;
    localparam int RUN_LEN = (2 * N + 3) * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic scl_pull_o, sda_pull_o, busy_o, done_o;

    int n_checks = 0;
    int n_fail = 0;

    int busy_len, falls_free, falls_all, bad_runs, sda_low, sda_low_rel;
    int tail_rel, done_cnt, bad_done, stop_ok, stop_bad, sda_in_train;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_clear_seq #(.HALF_CYCLES(H), .NUM_PULSES(N)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .scl_pull_o (scl_pull_o),
        .sda_pull_o (sda_pull_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one sequence; pokes start_i at sample index poke_at (-2 = at done sample)
    task automatic observe_run(input int poke_at);
        bit prev_scl = 0, prev_sda = 0, prev_busy = 0, seen_sda = 0;
        bit run_open = 0, done_seen = 0;
        int runlen = 0;
        busy_len = 0; falls_free = 0; falls_all = 0; bad_runs = 0; sda_low = 0;
        sda_low_rel = 0; tail_rel = 0; done_cnt = 0; bad_done = 0; stop_ok = 0;
        stop_bad = 0; sda_in_train = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int idx = 0; idx < 2000; idx++) begin
            if (busy_o) busy_len++;
            if (scl_pull_o && !prev_scl) begin
                falls_all++;
                if (!sda_pull_o) falls_free++;
            end
            if (scl_pull_o != prev_scl) begin
                if (run_open && runlen != H) bad_runs++;
                run_open = busy_o;
                runlen = 1;
            end else begin
                runlen++;
            end
            if (sda_pull_o) begin
                sda_low++;
                if (!scl_pull_o) sda_low_rel++;
            end
            if (sda_pull_o && falls_free < N) sda_in_train++;
            if (!sda_pull_o && prev_sda) begin
                if (!scl_pull_o && !prev_scl) stop_ok++;
                else stop_bad++;
            end
            if (sda_pull_o) seen_sda = 1;
            if (seen_sda && !sda_pull_o && busy_o) tail_rel++;
            if (done_o) begin
                done_cnt++;
                if (busy_o || !prev_busy) bad_done++;
            end
            if (done_seen && !done_o) break;
            if (done_o) done_seen = 1;
            start_i = (idx == poke_at) || (poke_at == -2 && done_o);
            prev_scl = scl_pull_o; prev_sda = sda_pull_o; prev_busy = busy_o;
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic test_reset();
        check(!scl_pull_o, "R1 scl after reset", scl_pull_o, 0);
        check(!sda_pull_o, "R1 sda after reset", sda_pull_o, 0);
        check(!busy_o,     "R1 busy after reset", busy_o, 0);
        check(!done_o,     "R1 done after reset", done_o, 0);
    endtask

    task automatic test_basic();
        observe_run(-1);
        check(falls_free == N,       "R2 free pulses", falls_free, N);
        check(falls_all == N + 1,    "R2 all scl lows", falls_all, N + 1);
        check(bad_runs == 0,         "R3 phase lengths", bad_runs, 0);
        check(sda_in_train == 0,     "R4 sda in train", sda_in_train, 0);
        check(sda_low == 2 * H,      "R5 sda low cycles", sda_low, 2 * H);
        check(sda_low_rel == H,      "R5 stop setup", sda_low_rel, H);
        check(stop_ok == 1,          "R5 stop edge", stop_ok, 1);
        check(stop_bad == 0,         "R5 bad sda release", stop_bad, 0);
        check(busy_len == RUN_LEN,   "R6 busy length", busy_len, RUN_LEN);
        check(tail_rel == H,         "R6 bus free tail", tail_rel, H);
        check(done_cnt == 1,         "R7 done width", done_cnt, 1);
        check(bad_done == 0,         "R7 done position", bad_done, 0);
    endtask

    task automatic test_poke_mid();
        observe_run(30);
        check(busy_len == RUN_LEN,   "R8 busy len with retrigger", busy_len, RUN_LEN);
        check(falls_free == N,       "R8 pulses with retrigger", falls_free, N);
    endtask

    task automatic test_poke_finish();
        int rises = 0;
        observe_run(-2);
        check(done_cnt == 1, "R8 done with late trigger", done_cnt, 1);
        for (int i = 0; i < 4 * H; i++) begin
            if (busy_o || scl_pull_o) rises++;
            @(negedge clk);
        end
        check(rises == 0, "R8 trigger in done cycle ignored", rises, 0);
    endtask

    task automatic test_back_to_back();
        int gap = 0;
        int guard = 0;
        @(negedge clk); start_i = 1'b1;
        while (!done_o && guard < 1000) begin guard++; @(negedge clk); end
        @(negedge clk);
        while (!busy_o && gap < 10) begin gap++; @(negedge clk); end
        check(gap == 1, "R9 idle gap between runs", gap, 1);
        check(scl_pull_o == 1'b1, "R9 second run pulls scl", scl_pull_o, 1);
        start_i = 1'b0;
        guard = 0;
        while (!done_o && guard < 1000) begin guard++; @(negedge clk); end
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset_mid();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (23) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!scl_pull_o && !sda_pull_o, "R1 lines released in reset",
              {30'd0, scl_pull_o, sda_pull_o}, 0);
        check(!busy_o, "R1 busy cleared in reset", busy_o, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        observe_run(-1);
        check(falls_free == N, "R2 pulses after mid-run reset", falls_free, N);
        check(busy_len == RUN_LEN, "R6 busy after mid-run reset", busy_len, RUN_LEN);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_basic();
        test_poke_mid();
        test_poke_finish();
        test_back_to_back();
        test_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule